// File: doc/BRIEF.md
# Chained Crosspoint Full-Frame Programmer

This block is the host-side engine that loads a whole chain of serially linked analog crosspoint switches in one transfer. Each device in the chain has eight outputs. Each output is set by a 5-bit field: a 4-bit input number and an off flag. The host presents the complete configuration for every device as one wide vector and pulses a start request. The block then drives chip select, a divided serial clock, serial data and a configure strobe, following the ordering rules the devices impose.

The serial clock runs at the system clock divided by 2·DIV. The devices sample data on the falling edge. The block therefore changes data only together with a rising edge, a full half-period before the sample. Chip select moves only while the clock is low. After the last bit, chip select is released and one extra clock pulse is issued. A single configure pulse then commits every device in the chain together. In the three-wire variant, the configure line is the chip-select line, so the commit happens when chip select rises. The mode line is held low, because chained loading works only in full-frame mode.

Top module: `xpt_chain_prog`

## Requirements
- R1: While reset is asserted and when idle, cs_n_o is 1, sclk_o is 0, done_o and busy_o are 0, and cfg_o is 0 (4-wire) or 1 (3-wire).
- R2: mode_o is 0 at all times.
- R3: cs_n_o falls in the cycle after an accepted start and stays low for DIV cycles with sclk_o low before the first rising edge. cs_n_o never changes while sclk_o is high.
- R4: Each high phase and each low phase of sclk_o lasts exactly DIV system cycles. A frame has NDEV·40 clock pulses with cs_n_o low.
- R5: sdo_o changes only in the cycle where sclk_o rises. It is stable through the high phase and across the falling edge.
- R6: Stream order: device NDEV-1 (the farthest) first, device 0 last. Within a device, the output 0 field comes first and the output 7 field last. Field o of device d is cfg_i[d*40+o*5 +: 5]. Bits 3:0 are the input number, sent LSB first, followed by bit 4, the off flag (1 means off).
- R7: After the low phase of the last bit, cs_n_o rises with sclk_o low. After DIV cycles, one more full sclk_o pulse (DIV high, DIV low) follows with cs_n_o high.
- R8: In 4-wire mode (THREE_WIRE=0), cfg_o stays low during shifting and the trailing pulse. It then goes high for exactly DIV cycles, once per frame.
- R9: In 3-wire mode (THREE_WIRE=1), cfg_o equals cs_n_o in every cycle, and no separate configure pulse occurs.
- R10: busy_o is 1 from the cycle after an accepted start until done_o. A start while busy_o is 1 is ignored.
- R11: done_o is high for one cycle. It rises in the cycle cfg_o falls (4-wire) or right after the trailing pulse (3-wire), and busy_o clears in the same cycle.
- R12: cfg_i is captured when start is accepted. Changes to it during a transfer do not alter the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to load the chain |
| cfg_i | input | NDEV*40 | Routing fields for all devices |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the first device |
| mode_o | output | 1 | Programming mode select, held low |
| cfg_o | output | 1 | Configure strobe |

## Verification
The bench builds two instances. The first has two devices, DIV=2 and the four-wire strobe. It covers far-device-first ordering across a device boundary and the separate commit pulse. The second has three devices, DIV=3 and THREE_WIRE=1. It covers a middle device in the chain, an odd phase length, and the configure line following chip select. In both instances, a start request and a changed configuration are injected mid-transfer, so the bench sees any leak of new data or any restarted frame.

// File: rtl/xpt_chain_prog.sv
module xpt_chain_prog #(
  parameter int NDEV       = 2,
  parameter int DIV        = 2,
  parameter int THREE_WIRE = 0,
  parameter int OUTS       = 8,
  parameter int SELW       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [NDEV*OUTS*(SELW+1)-1:0] cfg_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         cs_n_o,
  output logic                         sclk_o,
  output logic                         sdo_o,
  output logic                         mode_o,
  output logic                         cfg_o
);
  localparam int FRAME = OUTS * (SELW + 1);
  localparam int TOTAL = NDEV * FRAME;
  localparam int IW    = $clog2(TOTAL);
  localparam int PW    = $clog2(FRAME);
  localparam int DW    = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int CW    = $clog2(DIV);

  typedef enum logic [2:0] {IDLE, LEAD, HIGH, LOW, TGAP, TRISE, TFALL, CFGP} st_t;

  st_t              st_q;
  logic [CW-1:0]    cnt_q;
  logic [DW-1:0]    dev_q, nxt_dev;
  logic [PW-1:0]    pos_q, nxt_pos;
  logic [TOTAL-1:0] shadow_q;
  logic             cs_n_q, sclk_q, sdo_q, cfg_q, done_q, busy_q;
  logic [IW-1:0]    cur_idx, nxt_idx;
  logic             last_bit, phase_end;

  assign phase_end = (cnt_q == CW'(DIV - 1));
  assign last_bit  = (dev_q == '0) && (pos_q == PW'(FRAME - 1));

  always_comb begin
    if (pos_q == PW'(FRAME - 1)) begin
      nxt_pos = '0;
      nxt_dev = dev_q - 1'b1;
    end else begin
      nxt_pos = pos_q + 1'b1;
      nxt_dev = dev_q;
    end
  end

  assign cur_idx = IW'(dev_q) * IW'(FRAME) + IW'(pos_q);
  assign nxt_idx = IW'(nxt_dev) * IW'(FRAME) + IW'(nxt_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= IDLE;
      cnt_q    <= '0;
      dev_q    <= '0;
      pos_q    <= '0;
      shadow_q <= '0;
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b0;
      sdo_q    <= 1'b0;
      cfg_q    <= 1'b0;
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == IDLE) begin
        if (start_i) begin
          shadow_q <= cfg_i;
          cs_n_q   <= 1'b0;
          busy_q   <= 1'b1;
          cnt_q    <= '0;
          dev_q    <= DW'(NDEV - 1);
          pos_q    <= '0;
          st_q     <= LEAD;
        end
      end else if (!phase_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        case (st_q)
          LEAD: begin
            sclk_q <= 1'b1;
            sdo_q  <= shadow_q[cur_idx];
            st_q   <= HIGH;
          end
          HIGH: begin
            sclk_q <= 1'b0;
            st_q   <= LOW;
          end
          LOW: begin
            if (last_bit) begin
              cs_n_q <= 1'b1;
              st_q   <= TGAP;
            end else begin
              dev_q  <= nxt_dev;
              pos_q  <= nxt_pos;
              sdo_q  <= shadow_q[nxt_idx];
              sclk_q <= 1'b1;
              st_q   <= HIGH;
            end
          end
          TGAP: begin
            sclk_q <= 1'b1;
            st_q   <= TRISE;
          end
          TRISE: begin
            sclk_q <= 1'b0;
            st_q   <= TFALL;
          end
          TFALL: begin
            if (THREE_WIRE != 0) begin
              done_q <= 1'b1;
              busy_q <= 1'b0;
              st_q   <= IDLE;
            end else begin
              cfg_q <= 1'b1;
              st_q  <= CFGP;
            end
          end
          CFGP: begin
            cfg_q  <= 1'b0;
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= IDLE;
          end
          default: st_q <= IDLE;
        endcase
      end
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;
  assign sdo_o  = sdo_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign mode_o = 1'b0;
  assign cfg_o  = (THREE_WIRE != 0) ? cs_n_q : cfg_q;
endmodule

module xpt_chain_prog_chk #(
  parameter int DIV        = 2,
  parameter int THREE_WIRE = 0
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic cfg_o,
  input logic done_o,
  input logic busy_o
);
  int hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 0;
    else        hi_cnt <= sclk_o ? hi_cnt + 1 : 0;
  end

  a_r3_cs_moves_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o != $past(cs_n_o)) |-> (!sclk_o && !$past(sclk_o)));
  a_r5_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_o != $past(sdo_o)) |-> $rose(sclk_o));
  a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (hi_cnt == DIV));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r8_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (THREE_WIRE == 0 && cfg_o) |-> (cs_n_o && !sclk_o && busy_o));
endmodule

bind xpt_chain_prog xpt_chain_prog_chk #(.DIV(DIV), .THREE_WIRE(THREE_WIRE)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
  .cfg_o(cfg_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/xpt_chain_prog_tb_top.sv
`timescale 1ns/1ps
module xpt_lane #(
  parameter int NDEV = 2,
  parameter int DIV  = 2,
  parameter int TW   = 0
) (
  input  logic clk,
  input  logic rst_n,
  output int   errs,
  output int   checks,
  output logic fin
);
  localparam int W = NDEV * 40;

  typedef struct packed {
    logic cs, s, chk, d, cf, dn, bz;
  } ent_t;

  logic         start;
  logic [W-1:0] cfg;
  logic busy_o, done_o, cs_n_o, sclk_o, sdo_o, mode_o, cfg_o;
  ent_t q[$];
  logic cur_busy;

  xpt_chain_prog #(.NDEV(NDEV), .DIV(DIV), .THREE_WIRE(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg),
    .busy_o(busy_o), .done_o(done_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .mode_o(mode_o), .cfg_o(cfg_o)
  );

  function automatic logic cf(input logic cs, input logic p);
    return (TW != 0) ? cs : p;
  endfunction

  task automatic push(input int n, input logic cs, input logic s, input logic chk,
                      input logic d, input logic c, input logic dn, input logic bz);
    for (int i = 0; i < n; i++) q.push_back('{cs, s, chk, d, c, dn, bz});
  endtask

  // Expected per-cycle waveform of one full frame
  task automatic build(input logic [W-1:0] v);
    push(DIV, 0, 0, 0, 0, cf(0, 0), 0, 1);
    for (int j = 0; j < W; j++) begin
      logic b;
      b = v[(NDEV - 1 - j / 40) * 40 + (j % 40)];
      push(DIV, 0, 1, 1, b, cf(0, 0), 0, 1);
      push(DIV, 0, 0, 0, 0, cf(0, 0), 0, 1);
    end
    // R7: release, then one more pulse with chip select high
    push(DIV, 1, 0, 0, 0, cf(1, 0), 0, 1);
    push(DIV, 1, 1, 0, 0, cf(1, 0), 0, 1);
    push(DIV, 1, 0, 0, 0, cf(1, 0), 0, 1);
    if (TW == 0) push(DIV, 1, 0, 0, 0, 1, 0, 1);
    push(1, 1, 0, 0, 0, cf(1, 0), 1, 0);
  endtask

  always @(posedge clk) begin
    if (rst_n && start && !cur_busy) build(cfg);
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s lane NDEV=%0d TW=%0d t=%0t act=%0b exp=%0b", tag, NDEV, TW, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    ent_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = '{1, 0, 0, 0, cf(1, 0), 0, 0};
    cur_busy = e.bz;
    if (!rst_n) begin
      cmp("R1 cs_n", cs_n_o, 1'b1);
      cmp("R1 sclk", sclk_o, 1'b0);
      cmp("R1 cfg",  cfg_o,  cf(1, 0));
      cmp("R1 done", done_o, 1'b0);
      cmp("R1 busy", busy_o, 1'b0);
    end else begin
      cmp("R3 cs_n", cs_n_o, e.cs);
      cmp("R4 sclk", sclk_o, e.s);
      // R5 and R6: data compared on every cycle of each high phase
      if (e.chk) cmp("R6 sdo", sdo_o, e.d);
      cmp((TW != 0) ? "R9 cfg" : "R8 cfg", cfg_o, e.cf);
      cmp("R11 done", done_o, e.dn);
      cmp("R10 busy", busy_o, e.bz);
    end
    cmp("R2 mode", mode_o, 1'b0);
  end

  task automatic kick(input logic [W-1:0] v);
    @(negedge clk); #1;
    start = 1'b1; cfg = v;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] pa, pc;
    errs = 0; checks = 0; fin = 1'b0; start = 1'b0; cfg = '0; cur_busy = 1'b0;
    for (int f = 0; f < W / 5; f++) pa[f*5 +: 5] = 5'(f * 7 + 3);
    pc = '0;
    for (int d = 0; d < NDEV; d++) begin
      pc[d*40 +: 5]      = 5'(d + 1);
      pc[d*40 + 35 +: 5] = 5'(5'h10 | 5'(d + 9));
    end
    @(posedge rst_n);
    repeat (3) @(negedge clk);
    kick(pa);
    repeat (40) @(negedge clk);
    // R10 start during busy ignored; R12 new cfg_i mid-transfer has no effect
    #1; start = 1'b1; cfg = ~pa;
    @(negedge clk); #1; start = 1'b0;
    wait_idle();
    kick({W{1'b1}});
    wait_idle();
    kick(pc);
    wait_idle();
    kick('0);
    wait_idle();
    fin = 1'b1;
  end
endmodule

module xpt_chain_prog_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int e0, c0, e1, c1;
  logic f0, f1;
  int wd_err = 0;

  always #2.5 clk = ~clk;

  xpt_lane #(.NDEV(2), .DIV(2), .TW(0)) lane4_i (
    .clk(clk), .rst_n(rst_n), .errs(e0), .checks(c0), .fin(f0));
  xpt_lane #(.NDEV(3), .DIV(3), .TW(1)) lane3_i (
    .clk(clk), .rst_n(rst_n), .errs(e1), .checks(c1), .fin(f1));

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!(f0 === 1'b1 && f1 === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 100000) begin
      wd_err = 1;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
    end
    $display("Result: errors=%0d of %0d checks", e0 + e1 + wd_err, c0 + c1 + wd_err);
    $finish;
  end
endmodule